// File: doc/BRIEF.md
# Free-Running 32 kHz Sync Counter

A read-only timekeeping peripheral. An up-counter advances by one on every pulse of `tick_i`, a single-cycle enable already synchronized to the bus clock and produced at 32768 pulses per second. Software uses the count as a monotonic time base. After a block reset the count starts again from zero. It wraps silently at the top of its range.

A small register bus selects one of two registers. One holds a fixed identification code. The other holds the current count. Every access is answered in the cycle after its strobe, with read data and an error flag. Code that reads through a 16-bit path needs a coherent 32-bit value. A halfword read of the low half therefore stores the upper half of the same sample in a shadow register. A later halfword read of the high half returns that stored copy. Every write and every byte-wide access is refused with the error flag.

Top module: `sync32k_counter`

## Requirements
- R1: After reset the count is zero and the shadow is zero. The first cycle after reset shows `rdata_o` = 0 and `err_o` = 0.
- R2: The count rises by one in the cycle after each `tick_i` pulse and holds when `tick_i` is low. From 2^CNT_W-1 it wraps to 0 with no flag. It is read zero-extended to 32 bits.
- R3: The response to a strobe is registered and appears in the next cycle. A cycle with neither `rd_i` nor `wr_i` yields `rdata_o` = 0 and `err_o` = 0 in the following cycle.
- R4: A word read (`size_i` = 2) at address 0x00 returns the identification code 0x00000021 with no error.
- R5: A word read at address 0x10 returns the count as it stood in the strobe cycle. A tick in that same cycle is not included. There is no error.
- R6: A halfword read (`size_i` = 1) with address bit 1 clear addresses the register at the address with bits 1:0 cleared. It returns that register's bits 15:0, zero-extended. In the same cycle it stores bits 31:16 of the same sample in the shadow.
- R7: A halfword read with address bit 1 set returns the shadow, zero-extended. It raises no error, at any address.
- R8: Word reads, idle cycles and halfword reads of the high half leave the shadow unchanged.
- R9: Any strobe with `wr_i` high, at any address and size, returns 0 with `err_o` = 1. This holds even when `rd_i` is also high. The write changes neither the count nor the shadow.
- R10: A read with `size_i` = 0 (byte) or `size_i` = 3 (reserved) returns 0 with `err_o` = 1 and leaves the shadow unchanged.
- R11: A word read at any address other than 0x00 and 0x10 returns 0 with `err_o` = 1. This includes addresses with bits 1:0 nonzero. A low-half read of an unmapped register returns 0 with `err_o` = 1 and loads the shadow with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Synchronized 32.768 kHz count enable, one cycle wide |
| addr_i | input | AW | Byte address of the access |
| size_i | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data, valid in the cycle after the strobe |
| err_o | output | 1 | Access error, valid with `rdata_o` |

## Verification
A count tick and a read of the count can land in the same cycle. A low-half read can also coincide with the tick that carries the low half from 0xFFFF to 0x10000. The bench raises `tick_i` together with the strobe in both cases. It expects the pre-tick value in the reply. After the boundary read it expects a high-half read to return 0, not 1. A following word read must show the incremented count, which proves the tick was not lost. Writes issued together with ticks must still let the count advance while the shadow stays as it was.

// File: rtl/sync32k_pkg.sv
package sync32k_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    KIND_IDLE,
    KIND_ERR,
    KIND_WORD,
    KIND_HALF_LO,
    KIND_HALF_HI
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_REV,
    SEL_CNT
  } reg_sel_e;

  localparam logic [31:0] REV_CODE = 32'h0000_0021;
  localparam int unsigned OFS_REV  = 32'h00;
  localparam int unsigned OFS_CNT  = 32'h10;

endpackage

// File: rtl/sync32k_tick_counter.sv
module sync32k_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  output logic [31:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_q + 1'b1;  // wraps silently
  end

  generate
    if (CNT_W < 32) begin : g_ext
      assign count_o = {{(32-CNT_W){1'b0}}, count_q};
    end else begin : g_full
      assign count_o = count_q[31:0];
    end
  endgenerate

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_o));

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !$stable(count_o));

endmodule

// File: rtl/sync32k_decode.sv
module sync32k_decode
  import sync32k_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output acc_kind_e     kind_o,
  output reg_sel_e      sel_o
);

  acc_size_e     sz;
  logic [AW-1:0] base;
  logic          aligned;
  reg_sel_e      base_sel;

  assign sz      = acc_size_e'(size_i);
  assign base    = {addr_i[AW-1:2], 2'b00};
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    if (base == AW'(OFS_REV))      base_sel = SEL_REV;
    else if (base == AW'(OFS_CNT)) base_sel = SEL_CNT;
    else                           base_sel = SEL_NONE;
  end

  always_comb begin
    kind_o = KIND_IDLE;
    sel_o  = SEL_NONE;
    if (wr_i) begin
      kind_o = KIND_ERR;
    end else if (rd_i) begin
      unique case (sz)
        SZ_WORD: begin
          kind_o = KIND_WORD;
          sel_o  = aligned ? base_sel : SEL_NONE;
        end
        SZ_HALF: begin
          kind_o = addr_i[1] ? KIND_HALF_HI : KIND_HALF_LO;
          sel_o  = addr_i[1] ? SEL_NONE : base_sel;
        end
        default: kind_o = KIND_ERR;
      endcase
    end
  end

endmodule

// File: rtl/sync32k_shadow.sv
module sync32k_shadow (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cap_i,
  input  logic [15:0] cap_val_i,
  output logic [15:0] shadow_o
);

  logic [15:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shadow_q <= '0;
    else if (cap_i) shadow_q <= cap_val_i;
  end

  assign shadow_o = shadow_q;

  assert_shadow_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(shadow_o));

endmodule

// File: rtl/sync32k_counter.sv
module sync32k_counter
  import sync32k_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic [31:0]   rdata_o,
  output logic          err_o
);

  logic [31:0] count;
  logic [15:0] shadow;
  acc_kind_e   kind;
  reg_sel_e    sel;
  logic [31:0] reg_val;
  logic        cap;
  logic [31:0] rdata_d;
  logic        err_d;
  logic [31:0] rdata_q;
  logic        err_q;

  sync32k_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .count_o (count)
  );

  sync32k_decode #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .kind_o (kind),
    .sel_o  (sel)
  );

  // one counter sample feeds both halves; the tick lands after this edge
  always_comb begin
    unique case (sel)
      SEL_REV: reg_val = REV_CODE;
      SEL_CNT: reg_val = count;
      default: reg_val = '0;
    endcase
  end

  always_comb begin
    rdata_d = '0;
    err_d   = 1'b0;
    cap     = 1'b0;
    unique case (kind)
      KIND_ERR: err_d = 1'b1;
      KIND_WORD: begin
        rdata_d = reg_val;
        err_d   = (sel == SEL_NONE);
      end
      KIND_HALF_LO: begin
        rdata_d = {16'h0000, reg_val[15:0]};
        err_d   = (sel == SEL_NONE);
        cap     = 1'b1;
      end
      KIND_HALF_HI: rdata_d = {16'h0000, shadow};
      default: ;
    endcase
  end

  sync32k_shadow u_shd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cap_val_i (reg_val[31:16]),
    .shadow_o  (shadow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> (!err_o && rdata_o == '0));

  assert_write_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (err_o && rdata_o == '0));

  assert_byte_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == 2'd0) |=> (err_o && rdata_o == '0));

  assert_rev_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 2'd2 && addr_i == '0) |=> (!err_o && rdata_o == 32'h21));

endmodule

// File: tb/sim_sync32k_counter.sv
`timescale 1ns/1ps
module sim_sync32k_counter;

  localparam int AW    = 8;
  localparam int CNT_W = 17;
  localparam logic [31:0] MASK = (32'd1 << CNT_W) - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    size_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [31:0]   rdata_o;
  logic          err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_cnt = '0;
  logic [15:0] m_shd = '0;

  always #4 clk = ~clk;

  sync32k_counter #(.AW(AW), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .size_i(size_i), .rd_i(rd_i), .wr_i(wr_i), .rdata_o(rdata_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_at(input logic [7:0] a, output bit hit);
    hit = 1'b1;
    if (a == 8'h00) return 32'h21;
    if (a == 8'h10) return m_cnt;
    hit = 1'b0;
    return 32'h0;
  endfunction

  // caller is at a negedge
  task automatic acc(input string req, input bit rd, input bit wr,
                     input logic [1:0] sz, input logic [7:0] ad, input bit tk);
    logic [31:0] e_d, v;
    bit e_e, hit, cap;
    logic [15:0] n_shd;
    e_d = 0; e_e = 0; cap = 0; n_shd = m_shd;
    if (wr) e_e = 1;
    else if (rd) begin
      if (sz == 2'd2) begin
        v = reg_at(ad, hit); e_d = v; e_e = !hit;
      end else if (sz == 2'd1) begin
        if (ad[1]) e_d = {16'h0, m_shd};
        else begin
          v = reg_at(ad & 8'hFC, hit);
          e_d = {16'h0, v[15:0]}; e_e = !hit; cap = 1; n_shd = v[31:16];
        end
      end else e_e = 1;
    end
    rd_i = rd; wr_i = wr; size_i = sz; addr_i = ad; tick_i = tk;
    @(posedge clk);
    if (tk) m_cnt = (m_cnt + 1) & MASK;
    if (cap) m_shd = n_shd;
    @(negedge clk);
    rd_i = 0; wr_i = 0; tick_i = 0;
    chk(req, rdata_o, e_d);
    chk(req, {31'h0, err_o}, {31'h0, e_e});
  endtask

  task automatic tick_run(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      @(posedge clk);
      m_cnt = (m_cnt + 1) & MASK;
      @(negedge clk);
    end
    tick_i = 0;
  endtask

  task automatic idle_chk();
    @(posedge clk);
    @(negedge clk);
    chk("R3", rdata_o, 32'h0);
    chk("R3", {31'h0, err_o}, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1", rdata_o, 32'h0);
    chk("R1", {31'h0, err_o}, 32'h0);
    acc("R1", 1, 0, 2'd2, 8'h10, 0);
    acc("R1", 1, 0, 2'd1, 8'h12, 0);
    idle_chk();

    acc("R4", 1, 0, 2'd2, 8'h00, 0);
    acc("R6", 1, 0, 2'd1, 8'h01, 0);
    acc("R7", 1, 0, 2'd1, 8'h03, 0);

    tick_run(5);
    acc("R2", 1, 0, 2'd2, 8'h10, 0);
    acc("R5", 1, 0, 2'd2, 8'h10, 1);
    acc("R5", 1, 0, 2'd2, 8'h10, 0);
    idle_chk();

    for (int a = 0; a < 256; a++) acc("R11", 1, 0, 2'd2, 8'(a), a[2]);
    for (int a = 0; a < 256; a++) acc("R6_R7", 1, 0, 2'd1, 8'(a), a[3]);
    for (int a = 0; a < 256; a += 4) begin
      acc("R10", 1, 0, 2'd0, 8'(a), 0);
      acc("R10", 1, 0, 2'd3, 8'(a), 1);
    end
    acc("R10", 1, 0, 2'd1, 8'h12, 0);

    // writes: counter keeps ticking, shadow untouched, observed via reads
    acc("R6", 1, 0, 2'd1, 8'h00, 0);
    acc("R6", 1, 0, 2'd1, 8'h10, 0);
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++) acc("R9", (s == 1), 1, 2'(s), 8'(a), (s == 2));
    acc("R9", 1, 0, 2'd1, 8'h12, 0);
    acc("R9", 1, 0, 2'd2, 8'h10, 0);
    idle_chk();

    // low-half capture coinciding with the 0xFFFF -> 0x10000 tick
    tick_run(int'(32'hFFFF - m_cnt));
    acc("R6", 1, 0, 2'd1, 8'h10, 1);
    acc("R6", 1, 0, 2'd1, 8'h12, 0);
    acc("R5", 1, 0, 2'd2, 8'h10, 0);
    acc("R6", 1, 0, 2'd1, 8'h10, 0);
    acc("R8", 1, 0, 2'd2, 8'h00, 1);
    acc("R8", 1, 0, 2'd2, 8'h10, 0);
    acc("R8", 1, 0, 2'd1, 8'h12, 0);

    tick_run(int'(MASK - m_cnt));
    acc("R2", 1, 0, 2'd2, 8'h10, 1);
    acc("R2", 1, 0, 2'd2, 8'h10, 0);
    chk("R2", m_cnt, 32'h0);
    idle_chk();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule